// File: doc/BRIEF.md
# Supervisor and Virtual Timer Comparator

This block raises two timer interrupt pending levels for one hart. It holds a supervisor compare value, a virtual supervisor compare value and a 64-bit time offset. Each cycle it compares a free-running 64-bit time input against these registers and registers the result. The supervisor level compares raw time. The virtual level compares time plus the offset, with the sum wrapping at 64 bits. Both compares are unsigned.

Software reaches the three registers through a single-cycle CSR port. Reads are combinational and writes take effect at the clock edge. The `XLEN` parameter picks 32-bit or 64-bit access. With 32 bits, each 64-bit register is split into a low-half address and a high-half address, 0x10 above it. With 64 bits, the low address reaches the whole register, and the high-half addresses are flagged as illegal.

Gating by interrupt enables or delegation happens elsewhere, and so does the time counter.

Top module: `vtimer_cmp`

## Requirements
- R1: `s_pend` equals the unsigned result of `time_in >= scmp`, taken from the values present at the previous rising clock edge (one cycle of latency).
- R2: `vs_pend` equals the unsigned result of `(time_in + delta) mod 2^64 >= vcmp`, taken from the values present at the previous rising clock edge.
- R3: A pending level that is high stays high while time does not fall. It drops one cycle after the cycle in which its compare register is written to a value above the compared time.
- R4: While `rst_n` is low, both pending outputs are 0. Reset sets `scmp` to 0, `vcmp` to all ones and `delta` to 0.
- R5: Low-half addresses are 0x14D for `scmp`, 0x24D for `vcmp` and 0x605 for `delta`. With XLEN=64, a low-half address reads and writes all 64 bits. With XLEN=32, it reaches bits 31:0.
- R6: With XLEN=32, the high-half addresses 0x15D, 0x25D and 0x615 reach bits 63:32 of the same registers. A write to one half leaves the other half unchanged.
- R7: With XLEN=64, an access to a high-half address raises `csr_illegal` in the same cycle and reads 0. A write there changes no register. With XLEN=32, `csr_illegal` stays 0.
- R8: An access to any other address reads 0 and does not raise `csr_illegal`. A write there changes no register.
- R9: The virtual sum wraps. A time and offset whose true sum exceeds 2^64 − 1 compare using the low 64 bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | CSR access strobe |
| csr_we | input | 1 | Write when high, read when low |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational |
| csr_illegal | output | 1 | Access hit an address that does not exist at this XLEN |
| time_in | input | 64 | Free-running time value |
| s_pend | output | 1 | Supervisor timer pending level |
| vs_pend | output | 1 | Virtual supervisor timer pending level |

## Verification
If a compare or offset register is corrupted, the first clock edge where the wrong value changes the comparison makes a pending output differ. The fault then shows at the ports one cycle after that edge. If the wrong half is merged during a 32-bit access, the damage shows on the next read of the other half. It also shows when time crosses the mistaken value. For this reason, the reference model is compared against both pending outputs on every cycle, under both XLEN settings. Time steps are chosen to sit close to the programmed compare values, so a wrong bit near the crossing point flips the output within a few cycles.

// File: rtl/vtimer_cmp.sv
module vtimer_cmp #(
  parameter int XLEN = 64,
  parameter int AW = 12,
  parameter logic [AW-1:0] S_ADDR = 12'h14D,
  parameter logic [AW-1:0] V_ADDR = 12'h24D,
  parameter logic [AW-1:0] D_ADDR = 12'h605,
  parameter logic [AW-1:0] HI_OFS = 12'h010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_valid,
  input  logic            csr_we,
  input  logic [AW-1:0]   csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  input  logic [63:0]     time_in,
  output logic            s_pend,
  output logic            vs_pend
);
  localparam int NREG = 3;
  localparam bit RV32 = (XLEN == 32);
  localparam logic [NREG-1:0][AW-1:0] LO = {D_ADDR, V_ADDR, S_ADDR};

  logic [63:0]     rv [NREG];
  logic [NREG-1:0] hit_lo, hit_hi;
  logic [63:0]     wd64, rd64, vsum;

  assign wd64 = 64'(csr_wdata);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [63:0] RST = (i == 1) ? '1 : '0;
    logic [63:0] q;
    assign hit_lo[i] = csr_valid && (csr_addr == LO[i]);
    assign hit_hi[i] = csr_valid && (csr_addr == LO[i] + HI_OFS);
    assign rv[i] = q;
    if (RV32) begin : g_split
      always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else if (csr_we) begin
          if (hit_lo[i]) q[31:0]  <= wd64[31:0];
          if (hit_hi[i]) q[63:32] <= wd64[31:0];
        end
      end
    end else begin : g_full
      always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else if (csr_we && hit_lo[i]) q <= wd64;
      end
    end
  end

  always_comb begin
    rd64 = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_lo[i]) rd64 = rd64 | (RV32 ? {32'b0, rv[i][31:0]} : rv[i]);
      if (hit_hi[i] && RV32) rd64 = rd64 | {32'b0, rv[i][63:32]};
    end
  end

  assign csr_rdata   = rd64[XLEN-1:0];
  assign csr_illegal = !RV32 && (|hit_hi);
  assign vsum        = time_in + rv[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_pend  <= 1'b0;
      vs_pend <= 1'b0;
    end else begin
      s_pend  <= time_in >= rv[0];
      vs_pend <= vsum >= rv[1];
    end
  end
endmodule

module vtimer_cmp_chk #(
  parameter int XLEN = 64,
  parameter int AW = 12,
  parameter logic [AW-1:0] S_ADDR = 12'h14D,
  parameter logic [AW-1:0] D_ADDR = 12'h605,
  parameter logic [AW-1:0] HI_OFS = 12'h010
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_valid,
  input logic            csr_we,
  input logic [AW-1:0]   csr_addr,
  input logic [XLEN-1:0] csr_rdata,
  input logic            csr_illegal,
  input logic [63:0]     time_in,
  input logic            s_pend,
  input logic            vs_pend,
  input logic [63:0]     scmp,
  input logic [63:0]     vcmp,
  input logic [63:0]     delta
);
  logic wr_s, wr_d;
  logic [63:0] vsum;
  assign wr_s = csr_valid && csr_we && (csr_addr == S_ADDR || csr_addr == S_ADDR + HI_OFS);
  assign wr_d = csr_valid && csr_we && (csr_addr == D_ADDR || csr_addr == D_ADDR + HI_OFS);
  assign vsum = time_in + delta;

  AST_ZERO_CMP_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (scmp == 64'd0) |=> s_pend); // R1
  AST_ALLONES_NO_VPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (vcmp == '1 && vsum != '1) |=> !vs_pend); // R2
  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0 && XLEN == 64 && csr_valid)); // R7
  AST_SCMP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_s |=> $stable(scmp)); // R8
  AST_DELTA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_d |=> $stable(delta)); // R8
endmodule

bind vtimer_cmp vtimer_cmp_chk #(.XLEN(XLEN), .AW(AW), .S_ADDR(S_ADDR), .D_ADDR(D_ADDR), .HI_OFS(HI_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .time_in(time_in), .s_pend(s_pend),
  .vs_pend(vs_pend), .scmp(rv[0]), .vcmp(rv[1]), .delta(rv[2])
);

// File: tb/tb_vtimer_cmp.sv
`timescale 1ns/1ps
module tb_vtimer_cmp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, we = 1'b0;
  logic [11:0] a = '0;
  logic [63:0] wd = '0, tm = '0;
  logic [63:0] rd64;
  logic [31:0] rd32;
  logic ill64, ill32, s64, vs64, s32, vs32;

  always #5 clk = ~clk;

  vtimer_cmp #(.XLEN(64)) dut (.clk(clk), .rst_n(rst_n), .csr_valid(v), .csr_we(we), .csr_addr(a),
    .csr_wdata(wd), .csr_rdata(rd64), .csr_illegal(ill64), .time_in(tm), .s_pend(s64), .vs_pend(vs64));
  vtimer_cmp #(.XLEN(32)) dut32 (.clk(clk), .rst_n(rst_n), .csr_valid(v), .csr_we(we), .csr_addr(a),
    .csr_wdata(wd[31:0]), .csr_rdata(rd32), .csr_illegal(ill32), .time_in(tm), .s_pend(s32), .vs_pend(vs32));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [63:0] m64 [3];
  logic [63:0] m32 [3];
  bit e64s, e64v, e32s, e32v;
  logic [11:0] lo_a [3] = '{12'h14D, 12'h24D, 12'h605};

  function automatic int idx_lo(logic [11:0] ad);
    for (int i = 0; i < 3; i++) if (ad == lo_a[i]) return i;
    return -1;
  endfunction
  function automatic int idx_hi(logic [11:0] ad);
    for (int i = 0; i < 3; i++) if (ad == lo_a[i] + 12'h010) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [63:0] sum;
    int li, hi;
    if (!rst_n) begin
      m64 = '{64'd0, '1, 64'd0};
      m32 = '{64'd0, '1, 64'd0};
      e64s = 0; e64v = 0; e32s = 0; e32v = 0;
    end else begin
      e64s = tm >= m64[0];
      sum = tm + m64[2];
      e64v = sum >= m64[1];
      e32s = tm >= m32[0];
      sum = tm + m32[2];
      e32v = sum >= m32[1];
      if (v && we) begin
        li = idx_lo(a);
        hi = idx_hi(a);
        if (li >= 0) begin m64[li] = wd; m32[li][31:0] = wd[31:0]; end
        if (hi >= 0) m32[hi][63:32] = wd[31:0];
      end
    end
  end

  always @(negedge clk) if (!done) begin
    if (!rst_n) begin
      check("R4 s_pend in reset rv64", 64'(s64), 64'd0);
      check("R4 vs_pend in reset rv32", 64'(vs32), 64'd0);
    end else begin
      check("R1 s_pend rv64", 64'(s64), 64'(e64s));
      check("R2 vs_pend rv64", 64'(vs64), 64'(e64v));
      check("R1 s_pend rv32", 64'(s32), 64'(e32s));
      check("R2 vs_pend rv32", 64'(vs32), 64'(e32v));
    end
  end

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=100000", cyc);
      summary();
    end
  end

  task automatic exp_check(input string tag);
    int li, hi;
    logic [63:0] x64, x32;
    li = idx_lo(a); hi = idx_hi(a);
    x64 = (li >= 0) ? m64[li] : 64'd0;
    x32 = (li >= 0) ? {32'b0, m32[li][31:0]} : (hi >= 0) ? {32'b0, m32[hi][63:32]} : 64'd0;
    if (!we) begin
      check({tag, " rdata rv64"}, rd64, x64);
      check({tag, " rdata rv32"}, 64'(rd32), x32);
    end
    check({tag, " illegal rv64"}, 64'(ill64), 64'(hi >= 0));
    check({tag, " illegal rv32"}, 64'(ill32), 64'd0);
  endtask

  task automatic rd(input logic [11:0] ad, input string tag);
    @(negedge clk); v = 1; we = 0; a = ad;
    #1 exp_check(tag);
    @(negedge clk); v = 0;
  endtask

  task automatic wr(input logic [11:0] ad, input logic [63:0] d, input string tag);
    @(negedge clk); v = 1; we = 1; a = ad; wd = d;
    #1 exp_check(tag);
    @(negedge clk); v = 0; we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    rd(12'h14D, "R4");
    rd(12'h24D, "R4");
    rd(12'h605, "R4");
    tm = 64'd100;
    wr(12'h14D, 64'd200, "R5");
    idle(2);
    check("R1 below compare rv64", 64'(s64), 64'd0);
    check("R1 below compare rv32", 64'(s32), 64'd0);
    tm = 64'd250;
    idle(2);
    check("R1 at or above compare rv64", 64'(s64), 64'd1);
    tm = 64'd300;
    wr(12'h14D, 64'd1000, "R3");
    idle(1);
    check("R3 drops after larger write rv64", 64'(s64), 64'd0);
    check("R3 drops after larger write rv32", 64'(s32), 64'd0);
    wr(12'h14D, 64'h8000_0000_0000_0000, "R5");
    wr(12'h15D, 64'h8000_0000, "R7");
    idle(2);
    check("R1 unsigned top bit rv64", 64'(s64), 64'd0);
    check("R1 unsigned top bit rv32", 64'(s32), 64'd0);
    rd(12'h15D, "R7");
    wr(12'h605, 64'hFFFF_FFFF_FFFF_FF00, "R5");
    wr(12'h615, 64'hFFFF_FFFF, "R6");
    wr(12'h24D, 64'h50, "R5");
    wr(12'h25D, 64'h0, "R6");
    tm = 64'h100;
    idle(2);
    check("R9 wrapped sum below rv64", 64'(vs64), 64'd0);
    check("R9 wrapped sum below rv32", 64'(vs32), 64'd0);
    tm = 64'h150;
    idle(2);
    check("R9 wrapped sum reaches rv64", 64'(vs64), 64'd1);
    check("R9 wrapped sum reaches rv32", 64'(vs32), 64'd1);
    wr(12'h25D, 64'hDEAD, "R6");
    rd(12'h24D, "R6");
    rd(12'h25D, "R6");
    rd(12'h615, "R6");
    wr(12'h123, 64'h55, "R8");
    rd(12'h123, "R8");
    rd(12'h14D, "R8");
    wr(12'h24D, 64'h1234_5678_9ABC_DEF0, "R5");
    rd(12'h24D, "R5");
    for (int k = 0; k < 400; k++) begin
      logic [11:0] pick [7] = '{12'h14D, 12'h15D, 12'h24D, 12'h25D, 12'h605, 12'h615, 12'h0A0};
      logic [63:0] d;
      tm = tm + 64'($urandom % 6);
      if ($urandom % 50 == 0) tm = {$urandom, $urandom};
      if ($urandom % 3 == 0) begin
        d = ($urandom % 2 == 1) ? tm + 64'($urandom % 16) : {$urandom, $urandom};
        if ($urandom % 4 == 0) d = 64'($urandom % 64);
        wr(pick[$urandom % 7], d, "R5");
      end else if ($urandom % 4 == 0) begin
        rd(pick[$urandom % 7], "R6");
      end else idle(1);
    end
    idle(2);
    summary();
  end
endmodule